// File: doc/BRIEF.md
# Interrupt Controller with Halt and Stop Control

This block collects interrupt requests from the peripherals of a small CPU subsystem and presents them to the CPU on one IRQ line. Each peripheral pulses a request strobe for one cycle. The strobe latches a pending flag that software later clears by writing a one to the flag's position. A per-source enable mask decides which pending flags may wake the CPU from halt. A single master enable bit decides whether pending flags reach the IRQ line.

The register interface is byte wide and uses an address. Wider CPU accesses are assumed to be split into byte accesses before they reach the block. Reads are combinational from the current register state. A write to the power-control byte puts the CPU into halt or into stop. Halt ends by itself once any enabled flag is pending, whatever the master enable holds. Stop ends only on reset, because its wake sources are outside this block. A post-boot bit is stored for firmware.

Top module: `irq_hub`

## Requirements
- R1: After reset, the enable mask, pending flags, master enable and post-boot bit are all zero, cpu_irq, cpu_halt and cpu_stop are low, and every register address reads 0x00.
- R2: A write to offset 0 replaces enable bits 7:0. A write to offset 1 replaces enable bits 13:8 from data bits 5:0. Offset 1 reads bits 7:6 as zero.
- R3: A one-cycle pulse on src_req bit i sets pending flag i from the next clock edge. The bit order is: 0 vblank, 1 hblank, 2 line match, 3 to 6 timers 0 to 3, 7 serial, 8 to 11 DMA 0 to 3, 12 keypad, 13 cartridge. Flags read at offset 2 (bits 7:0) and offset 3 (bits 13:8, with bits 7:6 reading zero).
- R4: A write to offset 2 clears every flag in bits 7:0 whose data bit is 1. A write to offset 3 does the same for bits 13:8 using data bits 5:0. Data bits that are 0, and the other byte lane, leave flags unchanged.
- R5: When a request and a clear hit the same flag in the same cycle, the flag ends up set.
- R6: A write to offset 4 stores data bit 0 as the master enable, which reads back at bit 0 of offset 4. Offset 5 reads zero, and writes to it change nothing.
- R7: cpu_irq is high exactly when the master enable is 1 and at least one pending flag is set, regardless of the enable mask.
- R8: A write to offset 7 with data bit 7 equal to 1 makes cpu_stop high from the next edge. A write with data bit 7 equal to 0 makes cpu_halt high from the next edge. At most one of cpu_halt and cpu_stop is high.
- R9: While halted, cpu_halt falls at the first clock edge at which (enable AND flags) is non-zero, even when the master enable is 0. It stays high while that product is zero.
- R10: A write to offset 6 stores data bit 0 as the post-boot bit, which reads back at bit 0 of offset 6. Offset 7 always reads zero.
- R11: Once in stop, cpu_stop stays high until reset or another write to offset 7. Pending enabled flags do not end stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Byte write strobe for the addressed register |
| bus_addr | input | 3 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| src_req | input | 14 | One-cycle request strobes, one per source |
| cpu_irq | output | 1 | Interrupt line to the CPU |
| cpu_halt | output | 1 | CPU held in halt |
| cpu_stop | output | 1 | CPU held in stop |

## Verification
Every register write and every request strobe takes effect at the next clock edge. The read data, cpu_irq and the mode outputs are therefore due in the cycle that follows the stimulus. A halt release is due one edge after the enabled flag becomes visible, which is two edges after the request strobe. A behavioural model in the bench steps at each rising edge from the same inputs. The design outputs are compared with the model 2 ns after that edge, while the bench drives inputs only at falling edges. The directed checks sample at falling edges and count the exact number of edges from each stimulus, including the cycle in which halt must still be held.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

    localparam int unsigned REG_ADDR_W = 3;

    typedef enum logic [REG_ADDR_W-1:0] {
        OFS_EN_LO   = 3'd0,
        OFS_EN_HI   = 3'd1,
        OFS_FLAG_LO = 3'd2,
        OFS_FLAG_HI = 3'd3,
        OFS_MST_LO  = 3'd4,
        OFS_MST_HI  = 3'd5,
        OFS_BOOT    = 3'd6,
        OFS_PWR     = 3'd7
    } reg_ofs_e;

    typedef enum logic [1:0] {
        PM_RUN  = 2'd0,
        PM_HALT = 2'd1,
        PM_STOP = 2'd2
    } pmode_e;

    typedef struct packed {
        logic en_lo;
        logic en_hi;
        logic fl_lo;
        logic fl_hi;
        logic mst;
        logic boot;
        logic pwr;
    } wr_sel_t;

endpackage

// File: rtl/irq_hub_decode.sv
module irq_hub_decode
    import irq_hub_pkg::*;
(
    input  logic                  bus_wr,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    output wr_sel_t               sel
);
    always_comb begin
        sel = '0;
        if (bus_wr) begin
            case (reg_ofs_e'(bus_addr))
                OFS_EN_LO:   sel.en_lo = 1'b1;
                OFS_EN_HI:   sel.en_hi = 1'b1;
                OFS_FLAG_LO: sel.fl_lo = 1'b1;
                OFS_FLAG_HI: sel.fl_hi = 1'b1;
                OFS_MST_LO:  sel.mst   = 1'b1;
                OFS_BOOT:    sel.boot  = 1'b1;
                OFS_PWR:     sel.pwr   = 1'b1;
                default:     sel       = '0;
            endcase
        end
    end
endmodule

// File: rtl/irq_hub_pending.sv
module irq_hub_pending #(
    parameter int unsigned NSRC = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_lo,
    input  logic            clr_hi,
    input  logic [7:0]      wdata,
    input  logic [NSRC-1:0] req,
    output logic [NSRC-1:0] flag_q
);
    typedef struct packed {
        logic [NSRC-1:0] bits;
    } pend_t;

    pend_t           pend_d, pend_q;
    logic [NSRC-1:0] clr_bit;

    for (genvar i = 0; i < NSRC; i++) begin : g_lane
        localparam int unsigned LANE = i / 8;
        localparam int unsigned POS  = i % 8;
        if (LANE == 0) begin : g_lo
            assign clr_bit[i] = clr_lo & wdata[POS];
        end else begin : g_hi
            assign clr_bit[i] = clr_hi & wdata[POS];
        end
    end

    always_comb begin
        pend_d.bits = (pend_q.bits & ~clr_bit) | req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign flag_q = pend_q.bits;
endmodule

// File: rtl/irq_hub_power.sv
module irq_hub_power
    import irq_hub_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pwr_we,
    input  logic   stop_sel,
    input  logic   wake,
    output pmode_e mode_q
);
    typedef struct packed {
        pmode_e mode;
    } pwr_t;

    pwr_t pwr_d, pwr_q;

    always_comb begin
        pwr_d = pwr_q;
        if (pwr_q.mode == PM_HALT && wake) pwr_d.mode = PM_RUN;
        if (pwr_we) pwr_d.mode = stop_sel ? PM_STOP : PM_HALT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pwr_q <= '{mode: PM_RUN};
        else        pwr_q <= pwr_d;
    end

    assign mode_q = pwr_q.mode;
endmodule

// File: rtl/irq_hub.sv
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter int unsigned NSRC = 14
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [7:0]            bus_wdata,
    output logic [7:0]            bus_rdata,
    input  logic [NSRC-1:0]       src_req,
    output logic                  cpu_irq,
    output logic                  cpu_halt,
    output logic                  cpu_stop
);
    localparam int unsigned PAD_W = 16;

    typedef struct packed {
        logic [NSRC-1:0] en;
        logic            ime;
        logic            boot;
    } ctl_t;

    ctl_t            ctl_d, ctl_q;
    wr_sel_t         sel;
    logic [NSRC-1:0] flag_q;
    logic [NSRC-1:0] en_q;
    logic            ime_q;
    pmode_e          mode_q;
    logic [PAD_W-1:0] en_pad, flag_pad;

    irq_hub_decode u_dec (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .sel      (sel)
    );

    irq_hub_pending #(.NSRC(NSRC)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_lo (sel.fl_lo),
        .clr_hi (sel.fl_hi),
        .wdata  (bus_wdata),
        .req    (src_req),
        .flag_q (flag_q)
    );

    irq_hub_power u_pwr (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_we   (sel.pwr),
        .stop_sel (bus_wdata[7]),
        .wake     (|(ctl_q.en & flag_q)),
        .mode_q   (mode_q)
    );

    always_comb begin
        ctl_d = ctl_q;
        for (int i = 0; i < int'(NSRC); i++) begin
            if (i < 8 && sel.en_lo) ctl_d.en[i] = bus_wdata[i % 8];
            if (i >= 8 && sel.en_hi) ctl_d.en[i] = bus_wdata[i % 8];
        end
        if (sel.mst)  ctl_d.ime  = bus_wdata[0];
        if (sel.boot) ctl_d.boot = bus_wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign en_q     = ctl_q.en;
    assign ime_q    = ctl_q.ime;
    assign en_pad   = PAD_W'(ctl_q.en);
    assign flag_pad = PAD_W'(flag_q);

    always_comb begin
        case (reg_ofs_e'(bus_addr))
            OFS_EN_LO:   bus_rdata = en_pad[7:0];
            OFS_EN_HI:   bus_rdata = en_pad[15:8];
            OFS_FLAG_LO: bus_rdata = flag_pad[7:0];
            OFS_FLAG_HI: bus_rdata = flag_pad[15:8];
            OFS_MST_LO:  bus_rdata = {7'd0, ctl_q.ime};
            OFS_BOOT:    bus_rdata = {7'd0, ctl_q.boot};
            default:     bus_rdata = 8'd0;
        endcase
    end

    assign cpu_irq  = ctl_q.ime & (|flag_q);
    assign cpu_halt = (mode_q == PM_HALT);
    assign cpu_stop = (mode_q == PM_STOP);
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk
    import irq_hub_pkg::*;
#(
    parameter int unsigned NSRC = 14
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_wr,
    input logic [REG_ADDR_W-1:0] bus_addr,
    input logic [7:0]            bus_wdata,
    input logic [NSRC-1:0]       src_req,
    input logic                  cpu_irq,
    input logic                  cpu_halt,
    input logic                  cpu_stop,
    input logic [NSRC-1:0]       flag_q,
    input logic [NSRC-1:0]       en_q,
    input logic                  ime_q
);
    logic pwr_wr;
    assign pwr_wr = bus_wr && (bus_addr == OFS_PWR);

    assert_req_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (src_req != '0) |=> ((flag_q & $past(src_req)) == $past(src_req)));

    assert_zero_clear_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == OFS_FLAG_LO || bus_addr == OFS_FLAG_HI)
         && bus_wdata == 8'd0 && src_req == '0) |=> $stable(flag_q));

    assert_mst_hi_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_MST_HI) |=> $stable(ime_q));

    assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> (ime_q && flag_q != '0));

    assert_stop_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_wr && bus_wdata[7]) |=> (cpu_stop && !cpu_halt));

    assert_halt_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_wr && !bus_wdata[7]) |=> (cpu_halt && !cpu_stop));

    assert_modes_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({cpu_halt, cpu_stop}) <= 1);

    assert_halt_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_halt && (en_q & flag_q) != '0 && !pwr_wr) |=> !cpu_halt);

    assert_halt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_halt && (en_q & flag_q) == '0 && !pwr_wr) |=> cpu_halt);

    assert_stop_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_stop && !pwr_wr) |=> cpu_stop);
endmodule

bind irq_hub irq_hub_chk #(.NSRC(NSRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .src_req   (src_req),
    .cpu_irq   (cpu_irq),
    .cpu_halt  (cpu_halt),
    .cpu_stop  (cpu_stop),
    .flag_q    (flag_q),
    .en_q      (en_q),
    .ime_q     (ime_q)
);

// File: tb/tb_irq_hub.sv
`timescale 1ns/1ps
module tb_irq_hub;
    localparam int NSRC = 14;
    localparam int MASK = (1 << NSRC) - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_wr = 1'b0;
    logic [2:0]      bus_addr = 3'd0;
    logic [7:0]      bus_wdata = 8'd0;
    logic [7:0]      bus_rdata;
    logic [NSRC-1:0] src_req = '0;
    logic            cpu_irq, cpu_halt, cpu_stop;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // behavioural reference state; mode: 0 run, 1 halt, 2 stop
    int m_en = 0, m_flag = 0, m_ime = 0, m_boot = 0, m_mode = 0;

    always #4 clk = ~clk;

    irq_hub #(.NSRC(NSRC)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_req(src_req),
        .cpu_irq(cpu_irq), .cpu_halt(cpu_halt), .cpu_stop(cpu_stop)
    );

    task automatic chk(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic int model_read(int a);
        case (a)
            0: return m_en & 8'hFF;
            1: return (m_en >> 8) & 8'hFF;
            2: return m_flag & 8'hFF;
            3: return (m_flag >> 8) & 8'hFF;
            4: return m_ime;
            6: return m_boot;
            default: return 0;
        endcase
    endfunction

    function automatic string read_tag(int a);
        case (a)
            0, 1: return "R2";
            2, 3: return "R4";
            4, 5: return "R6";
            default: return "R10";
        endcase
    endfunction

    // reference model stepped at each rising edge, compared 2 ns later
    always @(posedge clk) begin
        int n_en, n_flag, n_ime, n_boot, n_mode, clr, w, a;
        if (!rst_n) begin
            m_en = 0; m_flag = 0; m_ime = 0; m_boot = 0; m_mode = 0;
        end else begin
            w = int'(bus_wdata); a = int'(bus_addr);
            n_en = m_en; n_ime = m_ime; n_boot = m_boot; n_mode = m_mode; clr = 0;
            if (bus_wr) begin
                if (a == 0) n_en = (m_en & 16'hFF00) | w;
                if (a == 1) n_en = ((m_en & 8'hFF) | (w << 8)) & MASK;
                if (a == 2) clr = w;
                if (a == 3) clr = (w << 8) & MASK;
                if (a == 4) n_ime = w & 1;
                if (a == 6) n_boot = w & 1;
            end
            n_flag = (m_flag & ~clr) | int'(src_req);
            if (m_mode == 1 && (m_en & m_flag) != 0) n_mode = 0;
            if (bus_wr && a == 7) n_mode = (w & 8'h80) != 0 ? 2 : 1;
            m_en = n_en; m_flag = n_flag; m_ime = n_ime; m_boot = n_boot; m_mode = n_mode;
        end
        #2;
        if (!rst_n) begin
            chk("R1 rdata", bus_rdata, 0);
            chk("R1 irq", cpu_irq, 0);
            chk("R1 mode", {cpu_stop, cpu_halt}, 0);
        end else begin
            chk({read_tag(int'(bus_addr)), " rdata"}, bus_rdata, model_read(int'(bus_addr)));
            chk("R7 irq", cpu_irq, (m_ime != 0 && m_flag != 0) ? 1 : 0);
            chk("R9 halt", cpu_halt, m_mode == 1 ? 1 : 0);
            chk("R8 stop", cpu_stop, m_mode == 2 ? 1 : 0);
        end
    end

    task automatic drive(bit wr, int a, int d, int req);
        @(negedge clk);
        bus_wr = wr; bus_addr = 3'(a); bus_wdata = 8'(d); src_req = NSRC'(req);
    endtask

    task automatic peek(int a, string tag, int exp);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 3'(a); src_req = '0;
        #1 chk(tag, bus_rdata, exp);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        for (int a = 0; a < 8; a++) begin
            bus_addr = 3'(a); #1 chk("R1 reset read", bus_rdata, 0);
        end
        rst_n = 1'b1;

        // R2 enable lanes
        drive(1, 0, 8'hA5, 0);
        drive(1, 1, 8'hFF, 0);
        peek(0, "R2 en lo", 8'hA5);
        peek(1, "R2 en hi upper bits zero", 8'h3F);

        // R3 requests: vblank(0), timer1(4), dma2(10)
        drive(0, 0, 0, (1 << 0) | (1 << 4) | (1 << 10));
        peek(2, "R3 flag lo", 8'h11);
        peek(3, "R3 flag hi", 8'h04);
        #1 chk("R7 irq off with master clear", cpu_irq, 0);

        // R6 master enable
        drive(1, 4, 8'hFF, 0);
        peek(4, "R6 master bit0", 1);
        #1 chk("R7 irq on", cpu_irq, 1);
        drive(1, 5, 8'h00, 0);
        peek(4, "R6 high byte ignored", 1);
        peek(5, "R6 high byte reads zero", 0);

        // R4 clear lanes
        drive(1, 2, 8'h01, 0);
        peek(2, "R4 clear bit0 keeps bit4", 8'h10);
        drive(1, 3, 8'h00, 0);
        peek(3, "R4 zero write keeps", 8'h04);
        drive(1, 2, 8'h04, 0);
        peek(3, "R4 other lane untouched", 8'h04);

        // R5 request beats clear
        drive(1, 2, 8'h10, 1 << 4);
        peek(2, "R5 request wins", 8'h10);

        // R9 halt with master enable clear
        drive(1, 2, 8'hFF, 0);
        drive(1, 3, 8'hFF, 0);
        drive(1, 4, 8'h00, 0);
        drive(1, 0, 8'h08, 0);
        drive(1, 1, 8'h00, 0);
        drive(1, 7, 8'h00, 0);
        peek(0, "R8 en readback", 8'h08);
        #1 chk("R8 halt entered", cpu_halt, 1);
        repeat (4) drive(0, 0, 0, 0);
        drive(0, 0, 0, 1 << 5);
        peek(2, "R9 unenabled flag set", 8'h20);
        #1 chk("R9 halt held by unenabled flag", cpu_halt, 1);
        drive(0, 0, 0, 1 << 3);
        peek(2, "R3 timer0 flag", 8'h28);
        #1 chk("R9 halt still set one edge after request", cpu_halt, 1);
        peek(2, "R9 flags", 8'h28);
        #1 chk("R9 halt released", cpu_halt, 0);
        #1 chk("R7 no irq with master clear", cpu_irq, 0);

        // R10 post-boot and power read
        drive(1, 6, 8'hFF, 0);
        peek(6, "R10 post-boot bit0", 1);
        peek(7, "R10 power reads zero", 0);

        // R11 stop
        drive(1, 7, 8'h80, 0);
        peek(7, "R11 power still zero", 0);
        #1 chk("R8 stop entered", cpu_stop, 1);
        drive(0, 0, 0, 1 << 3);
        repeat (3) drive(0, 0, 0, 0);
        #1 chk("R11 stop sticky", cpu_stop, 1);
        drive(1, 7, 8'h00, 0);
        peek(0, "R8 leave stop to halt", 8'h08);
        #1 chk("R8 stop low after halt write", cpu_stop, 0);

        // mixed traffic against the model
        for (int k = 0; k < 600; k++) begin
            int a;
            if (k % 150 == 0) begin
                @(negedge clk); rst_n = 1'b0;
                @(negedge clk); rst_n = 1'b1;
            end
            a = int'($urandom_range(0, 7));
            if (a == 7 && $urandom_range(0, 7) != 0) a = 2;
            drive($urandom_range(0, 2) == 0, a, int'($urandom_range(0, 255)),
                  int'($urandom & $urandom & $urandom) & MASK);
        end
        drive(0, 0, 0, 0);
        @(negedge clk);
        done = 1'b1;
        summary();
    end
endmodule